// File: doc/BRIEF.md
# Key-Sequence Serviced Watchdog Timer

This block is a watchdog timer with a 16-bit register interface on a simple single-cycle bus: address, write strobe, write data and combinational read data. It counts down at a slow timebase. Each pulse on the tick input stands for half a second. Software sets a timeout field and the enable bit. From then on, the only way to restart the countdown is to write an ordered two-word key to the service register. When the count runs out, the block drives a system reset pulse that lasts a fixed number of clock cycles. It records the cause in a status register and puts its own control state back to its reset values.

The enable bit cannot be cleared by software, and the freeze and timeout fields can be written only once. Firmware that has gone astray therefore cannot disarm the watchdog. Two suspend inputs can hold the count: one for low-power mode and one for an attached debugger. Each suspend applies only when its control bit allows it.

Firmware can force a reset. It writes the enable bit alone, which gives a timeout field of zero, and then gives the key. A reset follows one tick later.

Top module: `wdk_watchdog`

## Requirements
- R1: The control register is at byte address 0, the service register at 2 and the status register at 4. After power-on reset all three read 0x0000, and all three reset outputs are low. The service register always reads 0x0000.
- R2: Control bit 0 is the low-power freeze enable and bit 1 is the debug freeze enable. Bits 15:8 hold the timeout field WT. These three fields take their value only from the first control write after power-on reset or after a timeout. Later writes leave them unchanged. Bits 3 and 7 can be rewritten at any time. Bits 6:4 always read 0.
- R3: Control bit 2 is the enable. Once it is set, software writes cannot clear it. Only a timeout or a power-on reset clears it.
- R4: The control write that sets the enable loads the counter with WT. Every tick then takes one step. A system reset pulse starts at the edge of tick number WT+1 after the load, so the minimum timeout is one tick and the maximum is 256 ticks.
- R5: The counter is reloaded with WT when a service write of 0x5555 is followed by a service write of 0xAAAA, with no other service write between them. Writes to other registers do not break the sequence. Repeating 0x5555 keeps the sequence armed.
- R6: A service write of 0xAAAA that does not directly follow 0x5555 does not reload the counter. Any other service value discards a sequence that is half received.
- R7: While lp_i is high and control bit 0 is set, ticks do not change the count. The same holds while dbg_i is high and control bit 1 is set. If the matching bit is clear, the input has no effect.
- R8: sys_rst_o stays high for exactly RST_CYCLES clock cycles after a timeout. tmo_o follows it when control bit 3 was set at the timeout, and ext_rst_o follows it when control bit 7 was set.
- R9: After a timeout, the status register reads 0x0002 and the control register reads 0x0000. The status value survives later bus writes and is cleared only by power-on reset. Writes to the status register are ignored.
- R10: Writing control 0x0004 and then the key gives a reset pulse on the very next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| tick_i | input | 1 | One-cycle half-second timebase pulse |
| lp_i | input | 1 | Low-power mode indication |
| dbg_i | input | 1 | Debugger halt indication |
| bus_addr_i | input | 3 | Byte address of the register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational from address) |
| sys_rst_o | output | 1 | System reset pulse on timeout |
| tmo_o | output | 1 | Timeout indication gated by control bit 3 |
| ext_rst_o | output | 1 | External reset gated by control bit 7 |

## Verification
A count that is off by one, or a reload that is missed, shows up as a reset pulse one tick too early or too late. The bench therefore sweeps the timeout field and checks that sys_rst_o is low after exactly WT ticks and high after the next one. A key sequencer left armed when it should not be shows up as a delayed reset within two ticks of the bad service write. Lost write-once or sticky state shows up at once on a readback of the control register, or as a reset that never arrives. A wrong pulse counter shows up as the wrong pulse width, counted in clock cycles.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int TW = 8;

  localparam logic [AW-1:0] OFS_CTRL = 3'd0;
  localparam logic [AW-1:0] OFS_SVC  = 3'd2;
  localparam logic [AW-1:0] OFS_STAT = 3'd4;

  localparam logic [DW-1:0] KEY_A = 16'h5555;
  localparam logic [DW-1:0] KEY_B = 16'hAAAA;

  localparam int B_LP   = 0;
  localparam int B_DBG  = 1;
  localparam int B_EN   = 2;
  localparam int B_TMO  = 3;
  localparam int B_EXT  = 7;
  localparam int WT_LSB = 8;

  localparam logic [DW-1:0] STAT_TIMEOUT = 16'h0002;

  typedef struct packed {
    logic [TW-1:0] wt;
    logic          ext_sel;
    logic          tmo_sel;
    logic          en;
    logic          dbg_frz;
    logic          lp_frz;
  } ctrl_t;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  output ctrl_t         ctrl,
  output logic          svc_wr,
  output logic          en_load,
  output logic [TW-1:0] load_val,
  output logic [DW-1:0] rdata
);
  ctrl_t ctrl_q, ctrl_d;
  logic  locked_q, locked_d;
  logic  tmo_q, tmo_d;
  logic  ctrl_wr;
  logic  unused_wbits;

  assign unused_wbits = ^wdata[6:4];
  assign ctrl_wr = wr && (addr == OFS_CTRL);
  assign svc_wr  = wr && (addr == OFS_SVC);

  always_comb begin
    ctrl_d   = ctrl_q;
    locked_d = locked_q;
    tmo_d    = tmo_q;
    en_load  = 1'b0;
    if (expire) begin
      ctrl_d   = '0;
      locked_d = 1'b0;
      tmo_d    = 1'b1;
    end else if (ctrl_wr) begin
      if (!locked_q) begin
        ctrl_d.lp_frz  = wdata[B_LP];
        ctrl_d.dbg_frz = wdata[B_DBG];
        ctrl_d.wt      = wdata[WT_LSB +: TW];
        locked_d       = 1'b1;
      end
      ctrl_d.en      = ctrl_q.en | wdata[B_EN];
      ctrl_d.tmo_sel = wdata[B_TMO];
      ctrl_d.ext_sel = wdata[B_EXT];
      en_load        = ctrl_d.en && !ctrl_q.en;
    end
  end

  assign load_val = ctrl_d.wt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      locked_q <= locked_d;
      tmo_q    <= tmo_d;
    end
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL: begin
        rdata[WT_LSB +: TW] = ctrl_q.wt;
        rdata[B_EXT]        = ctrl_q.ext_sel;
        rdata[B_TMO]        = ctrl_q.tmo_sel;
        rdata[B_EN]         = ctrl_q.en;
        rdata[B_DBG]        = ctrl_q.dbg_frz;
        rdata[B_LP]         = ctrl_q.lp_frz;
      end
      OFS_STAT: rdata = tmo_q ? STAT_TIMEOUT : '0;
      default:  rdata = '0;
    endcase
  end

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && !expire) |=> ctrl_q.en);
  a_r2_wt_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !expire) |=> $stable(ctrl_q.wt));
  a_r9_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> tmo_q);
endmodule

// File: rtl/wdk_key.sv
module wdk_key
  import wdk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          svc_wr,
  input  logic [DW-1:0] wdata,
  input  logic          flush,
  output logic          reload
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    reload  = 1'b0;
    if (flush) begin
      armed_d = 1'b0;
    end else if (svc_wr) begin
      if (wdata == KEY_A) begin
        armed_d = 1'b1;
      end else begin
        reload  = armed_q && (wdata == KEY_B);
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  a_r5_arm_by_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(svc_wr && (wdata == KEY_A)));
  a_r6_other_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && (wdata != KEY_A)) |=> !armed_q);
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int TW         = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          freeze,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire,
  output logic          pulse
);
  localparam int PCW = $clog2(RST_CYCLES) + 1;
  localparam logic [PCW-1:0] PLAST = PCW'(RST_CYCLES - 1);

  logic [TW-1:0]  cnt_q, cnt_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           pulse_q, pulse_d;
  logic           step;

  assign step   = tick && en && !freeze;
  assign expire = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (expire)     cnt_d = '0;
    else if (load)  cnt_d = load_val;
    else if (step)  cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    pulse_d = pulse_q;
    pcnt_d  = pcnt_q;
    if (expire) begin
      pulse_d = 1'b1;
      pcnt_d  = '0;
    end else if (pulse_q) begin
      if (pcnt_q == PLAST) pulse_d = 1'b0;
      else                 pcnt_d  = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pcnt_q  <= pcnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && freeze && !load) |=> $stable(cnt_q));
  a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (pcnt_q <= PLAST));
  a_r4_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(tick && (cnt_q == '0)));
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog #(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        lp_i,
  input  logic        dbg_i,
  input  logic [2:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        sys_rst_o,
  output logic        tmo_o,
  output logic        ext_rst_o
);
  import wdk_pkg::*;

  logic [1:0]    rs_q;
  logic          rst_ni;
  ctrl_t         ctrl;
  logic          svc_wr, en_load, reload, expire, pulse, freeze;
  logic [TW-1:0] load_val;
  logic [1:0]    osel_q, osel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  wdk_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .wr(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .expire(expire), .ctrl(ctrl), .svc_wr(svc_wr),
    .en_load(en_load), .load_val(load_val), .rdata(bus_rdata_o)
  );

  wdk_key u_key (
    .clk(clk), .rst_n(rst_ni), .svc_wr(svc_wr), .wdata(bus_wdata_i),
    .flush(expire), .reload(reload)
  );

  assign freeze = (lp_i && ctrl.lp_frz) || (dbg_i && ctrl.dbg_frz);

  wdk_count #(.TW(TW), .RST_CYCLES(RST_CYCLES)) u_count (
    .clk(clk), .rst_n(rst_ni), .tick(tick_i), .en(ctrl.en), .freeze(freeze),
    .load(en_load || reload), .load_val(load_val), .expire(expire), .pulse(pulse)
  );

  always_comb begin
    osel_d = osel_q;
    if (expire) osel_d = {ctrl.ext_sel, ctrl.tmo_sel};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) osel_q <= 2'b00;
    else         osel_q <= osel_d;
  end

  assign sys_rst_o = pulse;
  assign tmo_o     = pulse && osel_q[0];
  assign ext_rst_o = pulse && osel_q[1];

  a_r8_gated_outputs: assert property (@(posedge clk) disable iff (!rst_ni)
    (tmo_o || ext_rst_o) |-> sys_rst_o);
endmodule

// File: tb/sim_wdk_watchdog.sv
module sim_wdk_watchdog;
  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n, tick_i, lp_i, dbg_i, bus_wr_i;
  logic [2:0]  bus_addr_i;
  logic [15:0] bus_wdata_i, bus_rdata_o;
  logic        sys_rst_o, tmo_o, ext_rst_o;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  always #4 clk = ~clk;

  wdk_watchdog #(.RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lp_i(lp_i), .dbg_i(dbg_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .sys_rst_o(sys_rst_o), .tmo_o(tmo_o),
    .ext_rst_o(ext_rst_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 0; lp_i = 0; dbg_i = 0; bus_wr_i = 0;
    bus_addr_i = 0; bus_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wait_pulse_end();
    while (sys_rst_o) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    logic [15:0] v;
    int plen;
    por();
    // R1 reset state
    rd(3'd0, v); check("R1 ctrl reset", v, 16'h0000);
    rd(3'd2, v); check("R1 svc reads zero", v, 16'h0000);
    rd(3'd4, v); check("R1 status reset", v, 16'h0000);
    check("R1 outputs low", {13'd0, sys_rst_o, tmo_o, ext_rst_o}, 16'h0000);

    // R4 R8 R9 timeout sweep
    for (int w = 0; w < 17; w++) begin
      int wt;
      logic ts, es;
      wt = (w == 16) ? 255 : w;
      ts = w[0]; es = w[1];
      por();
      wr(3'd0, 16'((wt << 8) | 4 | (int'(ts) << 3) | (int'(es) << 7)));
      ticks(wt);
      check("R4 no reset before WT+1 ticks", {15'd0, sys_rst_o}, 16'h0000);
      ticks(1);
      check("R4 reset at tick WT+1", {15'd0, sys_rst_o}, 16'h0001);
      check("R8 tmo_o gated by bit3", {15'd0, tmo_o}, {15'd0, ts});
      check("R8 ext_rst_o gated by bit7", {15'd0, ext_rst_o}, {15'd0, es});
      plen = 0;
      while (sys_rst_o) begin plen++; @(negedge clk); end
      check("R8 pulse length", 16'(plen + 1), 16'(RSTC));
      rd(3'd4, v); check("R9 status after timeout", v, 16'h0002);
      rd(3'd0, v); check("R9 ctrl cleared after timeout", v, 16'h0000);
    end

    // R9 status write ignored, cleared only by POR
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0100);
    rd(3'd4, v); check("R9 status survives writes", v, 16'h0002);
    por();
    wr(3'd4, 16'hFFFF);
    rd(3'd4, v); check("R9 status write ignored", v, 16'h0000);

    // R2 write-once and free bits
    por();
    wr(3'd0, 16'h0500); rd(3'd0, v); check("R2 first write", v, 16'h0500);
    wr(3'd0, 16'h0A07); rd(3'd0, v); check("R2 locked fields", v, 16'h0504);
    wr(3'd0, 16'h0088); rd(3'd0, v); check("R2 bits 3 7 writable", v, 16'h058C);
    wr(3'd0, 16'h0070); rd(3'd0, v); check("R2 bits 6:4 read 0", v, 16'h0504);

    // R3 sticky enable
    por();
    wr(3'd0, 16'h0304); wr(3'd0, 16'h0000);
    rd(3'd0, v); check("R3 enable stays set", v, 16'h0304);
    ticks(3); check("R3 still counting", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R3 timeout after clear attempt", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();

    // R5 good key reloads
    por();
    wr(3'd0, 16'h0304); ticks(3);
    wr(3'd2, 16'h5555); wr(3'd0, 16'h0000); wr(3'd2, 16'hAAAA);
    ticks(3); check("R5 reload delays reset", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R5 reset after reloaded period", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();
    por();
    wr(3'd0, 16'h0304); ticks(2);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    ticks(3); check("R5 repeated first key", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R5 repeated key period", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();

    // R6 bad sequences
    por();
    wr(3'd0, 16'h0304); ticks(2);
    wr(3'd2, 16'hAAAA);
    ticks(1); check("R6 lone second key", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R6 lone second key no reload", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();
    por();
    wr(3'd0, 16'h0304); ticks(2);
    wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
    ticks(1); check("R6 interrupted key", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R6 interrupted key no reload", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();

    // R7 freeze
    por();
    wr(3'd0, 16'h0305); lp_i = 1;
    ticks(10); check("R7 low-power freeze", {15'd0, sys_rst_o}, 16'h0000);
    lp_i = 0;
    ticks(3); check("R7 resumes after low-power", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R7 low-power timeout", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();
    por();
    wr(3'd0, 16'h0306); dbg_i = 1;
    ticks(10); check("R7 debug freeze", {15'd0, sys_rst_o}, 16'h0000);
    dbg_i = 0;
    ticks(3); check("R7 resumes after debug", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R7 debug timeout", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();
    por();
    wr(3'd0, 16'h0304); lp_i = 1; dbg_i = 1;
    ticks(3); check("R7 no freeze when bits clear", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R7 counts when bits clear", {15'd0, sys_rst_o}, 16'h0001);
    lp_i = 0; dbg_i = 0;
    wait_pulse_end();

    // R10 forced reset
    por();
    wr(3'd0, 16'h0004); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
    check("R10 no reset before tick", {15'd0, sys_rst_o}, 16'h0000);
    ticks(1); check("R10 reset on next tick", {15'd0, sys_rst_o}, 16'h0001);
    wait_pulse_end();

    done = 1;
    finish_up();
  end
endmodule